// File: doc/BRIEF.md
# Shared-Buffer Two-Port Cell Switch Core

This block switches fixed-length cells between two word-parallel inputs and two word-parallel outputs through one shared cell memory. A cell is 27 words of 16 bits: three header words, then 24 payload words. When a cell starts on an input, a write state machine claims a free slot from a pool of slot numbers. It writes the 27 words into that slot and, once the last word is stored, queues the slot number on the output queue or queues named by the header. A cell sent to both outputs is a copy cell and carries a one-bit flag per slot.

Each output has a read request. A read state machine that sees the request while its queue holds an entry takes the oldest slot number and streams the cell, one word per cycle, marking word 0. When the stream ends, the slot goes back to the free pool. For a copy cell, the first reader only clears the flag and the second reader frees the slot. The core keeps an occupancy count and pulses an alarm when a cell finds no free slot. Both inputs may start in the same cycle. Input 0 then claims its slot first and is queued ahead of input 1 on any output both cells share.

Writer states: `WR_IDLE` and `WR_FILL`. The claim transition WR_IDLE→WR_FILL happens on a granted start. The commit transition WR_FILL→WR_IDLE happens at the last word. Reader states: `RD_IDLE` and `RD_STREAM`. The fetch transition RD_IDLE→RD_STREAM happens on a request with a non-empty queue. The release transition RD_STREAM→RD_IDLE happens after the last word.

Top module: `cell_switch_core`

## Requirements
- R1: After reset, both `out_valid` bits are 0, `occupancy` is 0 and `overflow_alarm` is 0. All slots are free and both output queues are empty.
- R2: A cell starts with `in_sop[k]`=1 on word 0 and takes the next 26 cycles for words 1 to 26. Bits [1:0] of word 0 give the destination: bit 0 selects output 0 and bit 1 selects output 1.
- R3: A cell whose destination bits are 00 is discarded. It claims no slot, leaves `occupancy` unchanged and is queued on no output.
- R4: If `rd_req[k]` is sampled high while output queue k is not empty, output k streams one stored cell starting on the next cycle. The stream lasts 27 consecutive cycles with `out_valid[k]`=1, `out_sop[k]`=1 on the first word only, and the words in the order they were written.
- R5: Each output delivers its cells in the order in which they were committed to its queue.
- R6: A read request is ignored while its queue is empty or while that output is already streaming.
- R7: `occupancy` rises by one in the cycle after each accepted cell start. It falls by one in the cycle after the last word of the read that frees the slot.
- R8: A cell start with nonzero destination bits while no slot is free stores nothing and changes no queue. `overflow_alarm` is then 1 for exactly the following cycle.
- R9: A cell with destination bits 11 is queued on both outputs. Its slot is freed only after both outputs have read it. When both reads end in the same cycle, the slot is freed once.
- R10: Freed slots return to the pool. After every stored cell has been read out, all slots can be filled again without an alarm.
- R11: When both inputs start a cell in the same cycle, input 0 claims a slot first. On an output both cells go to, input 0's cell is delivered before input 1's. With one slot left, input 0 gets it and input 1 raises the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sop | input | 2 | Start of cell per input, high on word 0 |
| in_word | input | 2x16 | Input word per input |
| rd_req | input | 2 | Read-out request per output |
| out_valid | output | 2 | Output word valid per output |
| out_sop | output | 2 | First word of an output cell |
| out_word | output | 2x16 | Output word per output |
| occupancy | output | 4 | Number of slots holding a cell |
| overflow_alarm | output | 1 | One-cycle pulse when a cell found no free slot |

## Verification
`overflow_alarm` and the `occupancy` increase are registered from the start word. They are due in the cycle after the start, and the bench reads them at the falling edge that follows. The first output word appears in the cycle after the clock edge that samples the request. Each later word follows one cycle apart, so the bench compares one word per falling edge. The `occupancy` decrease appears one cycle after the last output word, where the bench checks it against its own count of pending reads.

// File: rtl/cellsw_pkg.sv
package cellsw_pkg;

    typedef enum logic {WR_IDLE, WR_FILL}   wr_state_e;
    typedef enum logic {RD_IDLE, RD_STREAM} rd_state_e;

    localparam logic [1:0] DEST_NONE = 2'b00;
    localparam logic [1:0] DEST_COPY = 2'b11;

    function automatic int unsigned ring_add(int unsigned p, int unsigned k, int unsigned depth);
        return (p + k >= depth) ? p + k - depth : p + k;
    endfunction

endpackage

// File: rtl/addr_queue.sv
module addr_queue
    import cellsw_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int AW      = 3,
    parameter bit PRELOAD = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_a,
    input  logic [AW-1:0]                din_a,
    input  logic                         push_b,
    input  logic [AW-1:0]                din_b,
    input  logic [1:0]                   pop_n,
    output logic [AW-1:0]                head0,
    output logic [AW-1:0]                head1,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH+1);

    logic [AW-1:0] ring [DEPTH];
    logic [PW-1:0] rd_p, wr_p;

    assign head0 = ring[rd_p];
    assign head1 = ring[PW'(ring_add(32'(rd_p), 32'd1, DEPTH))];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_p  <= '0;
            wr_p  <= '0;
            count <= PRELOAD ? CNTW'(DEPTH) : '0;
            for (int i = 0; i < DEPTH; i++) ring[i] <= PRELOAD ? AW'(i) : '0;
        end else begin
            if (push_a) ring[wr_p] <= din_a;
            if (push_b) ring[push_a ? PW'(ring_add(32'(wr_p), 32'd1, DEPTH)) : wr_p] <= din_b;
            wr_p  <= PW'(ring_add(32'(wr_p), 32'(push_a) + 32'(push_b), DEPTH));
            rd_p  <= PW'(ring_add(32'(rd_p), 32'(pop_n), DEPTH));
            count <= count + CNTW'(push_a) + CNTW'(push_b) - CNTW'(pop_n);
        end
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) + 32'(push_a) + 32'(push_b) <= DEPTH + 32'(pop_n));
    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pop_n) <= 32'(count));

endmodule

// File: rtl/cell_writer.sv
module cell_writer
    import cellsw_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int CELL_WORDS = 27,
    parameter int SLOTS      = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  sop,
    input  logic [WORD_W-1:0]                     word,
    output logic                                  alloc_req,
    input  logic                                  alloc_gnt,
    input  logic [$clog2(SLOTS)-1:0]              alloc_slot,
    output logic                                  we,
    output logic [$clog2(SLOTS*CELL_WORDS)-1:0]   waddr,
    output logic                                  commit,
    output logic [$clog2(SLOTS)-1:0]              commit_slot,
    output logic [1:0]                            commit_dest
);
    localparam int SW  = $clog2(SLOTS);
    localparam int IW  = $clog2(CELL_WORDS);
    localparam int MAW = $clog2(SLOTS*CELL_WORDS);
    localparam logic [IW-1:0] LAST = IW'(CELL_WORDS-1);

    wr_state_e     st, st_nx;
    logic [IW-1:0] idx;
    logic [SW-1:0] slot_q;
    logic [1:0]    dest_q;

    assign commit_slot = slot_q;
    assign commit_dest = dest_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= WR_IDLE;
            idx    <= '0;
            slot_q <= '0;
            dest_q <= '0;
        end else begin
            st <= st_nx;
            if (st == WR_IDLE && alloc_req && alloc_gnt) begin
                idx    <= IW'(1);
                slot_q <= alloc_slot;
                dest_q <= word[1:0];
            end else if (st == WR_FILL) begin
                idx <= (idx == LAST) ? '0 : idx + IW'(1);
            end
        end
    end

    always_comb begin
        st_nx     = st;
        alloc_req = 1'b0;
        we        = 1'b0;
        waddr     = '0;
        commit    = 1'b0;
        unique case (st)
            WR_IDLE: begin
                alloc_req = sop && (word[1:0] != DEST_NONE);
                if (alloc_req && alloc_gnt) begin
                    we    = 1'b1;
                    waddr = MAW'(alloc_slot) * MAW'(CELL_WORDS);
                    st_nx = WR_FILL;
                end
            end
            WR_FILL: begin
                we    = 1'b1;
                waddr = MAW'(slot_q) * MAW'(CELL_WORDS) + MAW'(idx);
                if (idx == LAST) begin
                    commit = 1'b1;
                    st_nx  = WR_IDLE;
                end
            end
            default: st_nx = WR_IDLE;
        endcase
    end

    // R2
    claim_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && alloc_gnt) |=> (we && !commit));

endmodule

// File: rtl/cell_reader.sv
module cell_reader
    import cellsw_pkg::*;
#(
    parameter int CELL_WORDS = 27,
    parameter int SLOTS      = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req,
    input  logic                                  q_nonempty,
    input  logic [$clog2(SLOTS)-1:0]              q_head,
    output logic                                  pop,
    output logic                                  done,
    output logic [$clog2(SLOTS)-1:0]              slot,
    output logic                                  out_valid,
    output logic                                  out_sop,
    output logic [$clog2(SLOTS*CELL_WORDS)-1:0]   raddr
);
    localparam int IW  = $clog2(CELL_WORDS);
    localparam int MAW = $clog2(SLOTS*CELL_WORDS);
    localparam logic [IW-1:0] LAST = IW'(CELL_WORDS-1);

    rd_state_e     st, st_nx;
    logic [IW-1:0] idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RD_IDLE;
            idx  <= '0;
            slot <= '0;
        end else begin
            st <= st_nx;
            if (pop) begin
                slot <= q_head;
                idx  <= '0;
            end else if (st == RD_STREAM) begin
                idx <= (idx == LAST) ? '0 : idx + IW'(1);
            end
        end
    end

    always_comb begin
        st_nx     = st;
        pop       = 1'b0;
        done      = 1'b0;
        out_valid = (st == RD_STREAM);
        out_sop   = (st == RD_STREAM) && (idx == '0);
        raddr     = MAW'(slot) * MAW'(CELL_WORDS) + MAW'(idx);
        unique case (st)
            RD_IDLE: begin
                if (req && q_nonempty) begin
                    pop   = 1'b1;
                    st_nx = RD_STREAM;
                end
            end
            RD_STREAM: begin
                if (idx == LAST) begin
                    done  = 1'b1;
                    st_nx = RD_IDLE;
                end
            end
            default: st_nx = RD_IDLE;
        endcase
    end

    // R4
    fetch_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (out_valid && out_sop));
    // R4
    stream_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !done) |=> (out_valid && !out_sop));
    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !done) |=> !$rose(pop));

endmodule

// File: rtl/cell_switch_core.sv
module cell_switch_core
    import cellsw_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int CELL_WORDS = 27,
    parameter int SLOTS      = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [1:0]                        in_sop,
    input  logic [1:0][WORD_W-1:0]            in_word,
    input  logic [1:0]                        rd_req,
    output logic [1:0]                        out_valid,
    output logic [1:0]                        out_sop,
    output logic [1:0][WORD_W-1:0]            out_word,
    output logic [$clog2(SLOTS+1)-1:0]        occupancy,
    output logic                              overflow_alarm
);
    localparam int SW   = $clog2(SLOTS);
    localparam int MAW  = $clog2(SLOTS*CELL_WORDS);
    localparam int CNTW = $clog2(SLOTS+1);

    logic [WORD_W-1:0] mem [SLOTS*CELL_WORDS];
    logic [SLOTS-1:0]  copy_flag;

    logic [1:0]     alloc_req, gnt, we, commit, pop, done, rel;
    logic [SW-1:0]  aslot [2];
    logic [MAW-1:0] waddr [2];
    logic [SW-1:0]  cslot [2];
    logic [1:0]     cdest [2];
    logic [SW-1:0]  rslot [2];
    logic [MAW-1:0] raddr [2];
    logic [SW-1:0]  oq_head0 [2];
    logic [SW-1:0]  oq_head1 [2];
    logic [CNTW-1:0] oq_cnt [2];

    logic [SW-1:0]   free_h0, free_h1;
    logic [CNTW-1:0] free_cnt;
    logic            both_same;

    // slot pool, preloaded with every slot in ascending order
    addr_queue #(.DEPTH(SLOTS), .AW(SW), .PRELOAD(1'b1)) u_free (
        .clk, .rst_n,
        .push_a(rel[0]), .din_a(rslot[0]),
        .push_b(rel[1]), .din_b(rslot[1]),
        .pop_n({1'b0, gnt[0]} + {1'b0, gnt[1]}),
        .head0(free_h0), .head1(free_h1), .count(free_cnt)
    );

    generate
        for (genvar g = 0; g < 2; g++) begin : g_port
            cell_writer #(.WORD_W(WORD_W), .CELL_WORDS(CELL_WORDS), .SLOTS(SLOTS)) u_wr (
                .clk, .rst_n,
                .sop(in_sop[g]), .word(in_word[g]),
                .alloc_req(alloc_req[g]), .alloc_gnt(gnt[g]), .alloc_slot(aslot[g]),
                .we(we[g]), .waddr(waddr[g]),
                .commit(commit[g]), .commit_slot(cslot[g]), .commit_dest(cdest[g])
            );

            addr_queue #(.DEPTH(SLOTS), .AW(SW), .PRELOAD(1'b0)) u_oq (
                .clk, .rst_n,
                .push_a(commit[0] && cdest[0][g]), .din_a(cslot[0]),
                .push_b(commit[1] && cdest[1][g]), .din_b(cslot[1]),
                .pop_n({1'b0, pop[g]}),
                .head0(oq_head0[g]), .head1(oq_head1[g]), .count(oq_cnt[g])
            );

            cell_reader #(.CELL_WORDS(CELL_WORDS), .SLOTS(SLOTS)) u_rd (
                .clk, .rst_n,
                .req(rd_req[g]), .q_nonempty(oq_cnt[g] != '0), .q_head(oq_head0[g]),
                .pop(pop[g]), .done(done[g]), .slot(rslot[g]),
                .out_valid(out_valid[g]), .out_sop(out_sop[g]), .raddr(raddr[g])
            );

            assign out_word[g] = out_valid[g] ? mem[raddr[g]] : '0;

            // R9
            dup_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (oq_cnt[g] >= CNTW'(2)) |-> (oq_head1[g] != oq_head0[g]));
        end
    endgenerate

    // slot grant: input 0 ahead of input 1
    always_comb begin
        gnt[0]   = alloc_req[0] && (free_cnt != '0);
        gnt[1]   = alloc_req[1] && (32'(free_cnt) > (gnt[0] ? 32'd1 : 32'd0));
        aslot[0] = free_h0;
        aslot[1] = gnt[0] ? free_h1 : free_h0;
    end

    // slot release, copy cells freed on their second read
    always_comb begin
        both_same = done[0] && done[1] && (rslot[0] == rslot[1]);
        rel[0]    = done[0] && (!copy_flag[rslot[0]] || both_same);
        rel[1]    = done[1] && !copy_flag[rslot[1]] && !both_same;
    end

    always_ff @(posedge clk) begin
        for (int g = 0; g < 2; g++) begin
            if (we[g]) mem[waddr[g]] <= in_word[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            copy_flag      <= '0;
            occupancy      <= '0;
            overflow_alarm <= 1'b0;
        end else begin
            for (int g = 0; g < 2; g++) begin
                if (gnt[g]) copy_flag[aslot[g]] <= (in_word[g][1:0] == DEST_COPY);
                if (done[g] && copy_flag[rslot[g]]) copy_flag[rslot[g]] <= 1'b0;
            end
            occupancy <= occupancy + CNTW'(gnt[0]) + CNTW'(gnt[1])
                                   - CNTW'(rel[0]) - CNTW'(rel[1]);
            overflow_alarm <= (alloc_req[0] && !gnt[0]) || (alloc_req[1] && !gnt[1]);
        end
    end

    // R7
    occ_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(occupancy) + 32'(free_cnt) == SLOTS);
    // R8
    full_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sop[0] && in_word[0][1:0] != DEST_NONE && free_cnt == '0) |=> overflow_alarm);
    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt == '0 && rel == 2'b00) |=> (32'(occupancy) == SLOTS));

endmodule

// File: tb/sim_cell_switch_core.sv
module sim_cell_switch_core;
    localparam int W  = 16;
    localparam int CW = 27;
    localparam int SL = 8;
    localparam int OW = $clog2(SL+1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [1:0]        in_sop = '0;
    logic [1:0][W-1:0] in_word = '0;
    logic [1:0]        rd_req = '0;
    logic [1:0]        out_valid, out_sop;
    logic [1:0][W-1:0] out_word;
    logic [OW-1:0]     occupancy;
    logic              overflow_alarm;

    cell_switch_core #(.WORD_W(W), .CELL_WORDS(CW), .SLOTS(SL)) u0 (
        .clk, .rst_n, .in_sop, .in_word, .rd_req,
        .out_valid, .out_sop, .out_word, .occupancy, .overflow_alarm
    );

    int n_vec = 0;
    int n_bad = 0;
    int q0[$];
    int q1[$];
    int model_occ = 0;
    int next_id = 1;
    logic [1:0] dest_of [4096];
    int         reads_left [4096];

    function automatic logic [W-1:0] word_of(int id, int i, logic [1:0] d);
        if (i == 0) return {id[13:0], d};
        return W'(id * 37 + i * 101 + (i << 9));
    endfunction

    task automatic check(bit ok, string rq, longint act, longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic accept(int id, logic [1:0] d, inout bit al);
        if (d == 2'b00) return;
        if (model_occ >= SL) begin
            al = 1'b1;
            return;
        end
        model_occ++;
        reads_left[id] = (d == 2'b11) ? 2 : 1;
        if (d[0]) q0.push_back(id);
        if (d[1]) q1.push_back(id);
    endtask

    // R2 R11: send one cell on each enabled input, same start cycle
    task automatic send(bit v0, logic [1:0] d0, bit v1, logic [1:0] d1);
        int id0;
        int id1;
        bit exp_al;
        exp_al = 1'b0;
        id0 = next_id++;
        id1 = next_id++;
        dest_of[id0] = d0;
        dest_of[id1] = d1;
        if (v0) accept(id0, d0, exp_al);
        if (v1) accept(id1, d1, exp_al);
        for (int i = 0; i < CW; i++) begin
            @(negedge clk);
            if (i == 1) begin
                check(overflow_alarm == exp_al, "R8 alarm", overflow_alarm, exp_al);
                check(32'(occupancy) == model_occ, "R7 occupancy after start", occupancy, model_occ);
            end
            if (i == 2) check(overflow_alarm == 1'b0, "R8 alarm width", overflow_alarm, 0);
            in_sop     = {v1 && i == 0, v0 && i == 0};
            in_word[0] = v0 ? word_of(id0, i, d0) : '0;
            in_word[1] = v1 ? word_of(id1, i, d1) : '0;
        end
        @(negedge clk);
        in_sop  = '0;
        in_word = '0;
    endtask

    // R4 R5 R6: request on selected outputs, request held into the stream
    task automatic do_read(bit r0, bit r1, string tag);
        int  id [2];
        bit  act [2];
        bit  r [2];
        r[0] = r0;
        r[1] = r1;
        act[0] = r0 && (q0.size() != 0);
        act[1] = r1 && (q1.size() != 0);
        id[0] = act[0] ? q0.pop_front() : 0;
        id[1] = act[1] ? q1.pop_front() : 0;
        @(negedge clk);
        rd_req = {r[1], r[0]};
        @(negedge clk);
        for (int i = 0; i < CW; i++) begin
            for (int g = 0; g < 2; g++) begin
                if (act[g]) begin
                    check(out_valid[g] && (out_sop[g] == (i == 0)) &&
                          out_word[g] == word_of(id[g], i, dest_of[id[g]]),
                          {tag, " R4 R5 stream word"}, out_word[g], word_of(id[g], i, dest_of[id[g]]));
                end else begin
                    check(!out_valid[g], {tag, " R6 idle output"}, out_valid[g], 0);
                end
            end
            if (i == 9) rd_req = '0;
            @(negedge clk);
        end
        rd_req = '0;
        for (int g = 0; g < 2; g++) begin
            check(!out_valid[g], {tag, " R6 held request ignored"}, out_valid[g], 0);
            if (act[g]) begin
                reads_left[id[g]]--;
                if (reads_left[id[g]] == 0) model_occ--;
            end
        end
        check(32'(occupancy) == model_occ, {tag, " R7 occupancy after read"}, occupancy, model_occ);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1
        check(out_valid == 2'b00, "R1 reset out_valid", out_valid, 0);
        check(occupancy == '0, "R1 reset occupancy", occupancy, 0);
        check(overflow_alarm == 1'b0, "R1 reset alarm", overflow_alarm, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 2'b00 && occupancy == '0, "R1 after reset", occupancy, 0);

        // R2 single cells to each output
        send(1, 2'b01, 0, 2'b00);
        do_read(1, 0, "R2");
        send(0, 2'b00, 1, 2'b10);
        do_read(0, 1, "R2");

        // R3 discarded cell
        send(1, 2'b00, 0, 2'b00);
        check(occupancy == '0, "R3 dropped occupancy", occupancy, 0);
        do_read(1, 1, "R3");

        // R9 copy cell read separately, then simultaneously
        send(1, 2'b11, 0, 2'b00);
        do_read(1, 0, "R9 first");
        check(32'(occupancy) == 1, "R9 slot kept after first read", occupancy, 1);
        do_read(0, 1, "R9 second");
        send(0, 2'b00, 1, 2'b11);
        do_read(1, 1, "R9 same cycle");
        check(occupancy == '0, "R9 freed once", occupancy, 0);

        // R11 simultaneous starts to one output
        send(1, 2'b01, 1, 2'b01);
        do_read(1, 0, "R11 first");
        do_read(1, 0, "R11 second");

        // R8 R11 fill, collide on last slot, refuse when full
        for (int k = 0; k < SL - 1; k++) send(1, 2'b01, 0, 2'b00);
        send(1, 2'b01, 1, 2'b10);
        send(1, 2'b10, 0, 2'b00);
        check(32'(occupancy) == SL, "R8 full occupancy", occupancy, SL);
        for (int k = 0; k < SL; k++) do_read(1, 1, "R8 drain");

        // R10 refill every slot after draining
        for (int k = 0; k < SL; k++) send(0, 2'b00, 1, 2'b10);
        check(32'(occupancy) == SL, "R10 refilled", occupancy, SL);
        for (int k = 0; k < SL; k++) do_read(0, 1, "R10 drain");

        // random mix
        for (int k = 0; k < 350; k++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0: send(1, 2'($urandom % 4), 0, 2'b00);
                1: send(0, 2'b00, 1, 2'($urandom % 4));
                2: send(1, 2'($urandom % 4), 1, 2'($urandom % 4));
                default: do_read(1'($urandom % 2), 1'($urandom % 2), "RND");
            endcase
        end
        while (q0.size() != 0 || q1.size() != 0) do_read(1, 1, "R10 final drain");
        check(occupancy == '0, "R10 empty at end", occupancy, 0);
        finish_run();
    end

endmodule